// File: doc/BRIEF.md
# Command-Driven Set-Associative Translation Buffer

This block holds the main translation array of a software-managed memory management unit. Software fills, searches and inspects the array through four registers. There are two descriptor words: the tag word and the data word. There is also an index word and a command word. Writing the command word starts one operation on the array:
- search (probe) the set for a tag,
- pick a slot for a new entry,
- store the descriptors with or without invalidating the small per-port caches downstream,
- load the descriptors back,
- or invalidate only those downstream caches.

Each command takes exactly one cycle to execute and signals completion with a strobe.

A separate combinational lookup port takes a virtual page number and an address-space identifier. It returns hit, duplicate-hit and the matching data word. Entries are addressed linearly as `set * WAYS + way`, so all ways of one set sit at consecutive indices. The downstream micro-caches are not part of this block. It only drives their invalidate pulse.

Top module: `xlate_buf`

## Requirements
- R1: After reset the tag, data and index words read as zero, every entry is blank (a lookup misses), and `busy`, `cmd_done` and `utlb_inv` are low.
- R2: While idle, a register write with `reg_sel` 0 (tag), 1 (data) or 2 (index) updates that word, and `reg_rdata` returns the selected word combinationally. Selector 3 reads `{31'b0, busy}`.
- R3: A write with `reg_sel`=3 captures command code `reg_wdata[2:0]`. `busy` is high for the next cycle only, then `cmd_done` is high for one cycle with the results visible. Any register write made while `busy` is high is ignored.
- R4: Command 3 (store) copies the tag and data words into the entry named by the index bits `[IDX_W-1:0]` and pulses `utlb_inv` together with `cmd_done`.
- R5: Command 4 (quiet store) stores exactly like command 3 but leaves `utlb_inv` low.
- R6: Command 6 pulses `utlb_inv` with `cmd_done` and leaves every entry unchanged.
- R7: Command 5 (load) replaces the tag and data words with the entry named by the index word.
- R8: An entry matches when all of the following hold:
  - its valid bit 9 is set;
  - its bits `[31:12]` (virtual page) equal those of the key;
  - either its global bit 8 is set, or its bits `[7:0]` (address-space identifier) equal the key's.
  The set is chosen by the low `log2(SETS)` bits of the virtual page. Command 1 (probe) with exactly one matching way loads the index word with `set*WAYS+way`, error bits clear.
- R9: A probe with no match loads the index word with `0x8000_0000` (bit 31 = lookup error). A probe with two or more matches loads `0xC000_0000` (bits 31 and 30, duplicate).
- R10: Command 2 (pick slot) loads the index word with the lowest way of the probed set whose valid bit is clear. If no way is free, it uses that set's round-robin way pointer. The pointer starts at 0 and advances by one, modulo WAYS, on every pick-slot command for that set.
- R11: The lookup port reports `lk_hit` when any way matches, `lk_dup` when more than one matches, and `lk_data` = data word of the lowest matching way (zero on a miss), all in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | asynchronous active-low reset |
| reg_we | input | 1 | register write strobe |
| reg_sel | input | 2 | register select: 0 tag, 1 data, 2 index, 3 command |
| reg_wdata | input | 32 | register write data |
| reg_rdata | output | 32 | selected register contents |
| busy | output | 1 | command executing this cycle |
| cmd_done | output | 1 | one-cycle completion strobe |
| utlb_inv | output | 1 | micro-cache invalidate pulse |
| lk_vpn | input | 20 | lookup virtual page number |
| lk_asid | input | 8 | lookup address-space identifier |
| lk_hit | output | 1 | lookup found a matching way |
| lk_dup | output | 1 | lookup matched more than one way |
| lk_data | output | 32 | data word of the matching entry |

## Verification
The probe is tried with a single private match, a global entry searched under a foreign identifier, a right page under the wrong identifier, a wrong page in an occupied set, and two identical entries in one set. Together these separate the hit, miss and duplicate encodings. Pick-slot runs on an empty set, a half-full set and a full set twice in a row, which separates lowest-free choice from round-robin rotation. Stores with and without invalidate, and the standalone invalidate, are told apart by the pulse and by reading the array back. A write during `busy` shows that the busy guard holds. A long pseudo-random run with indices confined to a few sets is then compared with a behavioural model on every clock.

// File: rtl/xbuf_pkg.sv
package xbuf_pkg;
    typedef enum logic [2:0] {
        OP_NOP      = 3'd0,
        OP_PROBE    = 3'd1,
        OP_PICK     = 3'd2,
        OP_STORE    = 3'd3,
        OP_STORE_Q  = 3'd4,
        OP_LOAD     = 3'd5,
        OP_UINV     = 3'd6
    } op_e;

    localparam int WORD_W     = 32;
    localparam int VPN_LSB    = 12;
    localparam int VPN_W      = WORD_W - VPN_LSB;
    localparam int ASID_W     = 8;
    localparam int VALID_BIT  = 9;
    localparam int GLOBAL_BIT = 8;
    localparam int ERR_BIT    = 31;
    localparam int DUP_BIT    = 30;

    localparam logic [1:0] SEL_TAG  = 2'd0;
    localparam logic [1:0] SEL_DATA = 2'd1;
    localparam logic [1:0] SEL_IDX  = 2'd2;
    localparam logic [1:0] SEL_CMD  = 2'd3;
endpackage

// File: rtl/xb_store.sv
module xb_store
    import xbuf_pkg::*;
#(
    parameter int WAYS = 2,
    parameter int SETS = 128
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              we,
    input  logic [$clog2(WAYS*SETS)-1:0]      waddr,
    input  logic [WORD_W-1:0]                 wtag,
    input  logic [WORD_W-1:0]                 wdata,
    input  logic [$clog2(SETS)-1:0]           set_a,
    output logic [WAYS-1:0][WORD_W-1:0]       a_tag,
    input  logic [$clog2(SETS)-1:0]           set_b,
    output logic [WAYS-1:0][WORD_W-1:0]       b_tag,
    output logic [WAYS-1:0][WORD_W-1:0]       b_data,
    input  logic [$clog2(WAYS*SETS)-1:0]      raddr,
    output logic [WORD_W-1:0]                 r_tag,
    output logic [WORD_W-1:0]                 r_data
);
    localparam int WAY_W   = $clog2(WAYS);
    localparam int ENTRIES = WAYS * SETS;

    logic [WORD_W-1:0] tag_mem  [ENTRIES];
    logic [WORD_W-1:0] data_mem [ENTRIES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < ENTRIES; i++) begin
                tag_mem[i]  <= '0;
                data_mem[i] <= '0;
            end
        end else if (we) begin
            tag_mem[waddr]  <= wtag;
            data_mem[waddr] <= wdata;
        end
    end

    for (genvar w = 0; w < WAYS; w++) begin : g_way
        assign a_tag[w]  = tag_mem[{set_a, WAY_W'(w)}];
        assign b_tag[w]  = tag_mem[{set_b, WAY_W'(w)}];
        assign b_data[w] = data_mem[{set_b, WAY_W'(w)}];
    end

    assign r_tag  = tag_mem[raddr];
    assign r_data = data_mem[raddr];
endmodule

// File: rtl/xb_way_match.sv
module xb_way_match
    import xbuf_pkg::*;
#(
    parameter int WAYS = 2
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [WAYS-1:0][WORD_W-1:0]  tags,
    input  logic [VPN_W-1:0]             key_vpn,
    input  logic [ASID_W-1:0]            key_asid,
    output logic                         hit_any,
    output logic                         hit_dup,
    output logic [$clog2(WAYS)-1:0]      hit_way
);
    localparam int WAY_W = $clog2(WAYS);

    logic [WAYS-1:0] hit_vec;

    for (genvar w = 0; w < WAYS; w++) begin : g_cmp
        assign hit_vec[w] = tags[w][VALID_BIT]
                          && (tags[w][WORD_W-1:VPN_LSB] == key_vpn)
                          && (tags[w][GLOBAL_BIT] || (tags[w][ASID_W-1:0] == key_asid));
    end

    always_comb begin
        hit_any = 1'b0;
        hit_dup = 1'b0;
        hit_way = '0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (hit_vec[w]) begin
                if (hit_any) hit_dup = 1'b1;
                hit_any = 1'b1;
                hit_way = WAY_W'(w);
            end
        end
    end

    // R9
    dup_implies_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hit_dup |-> hit_any);
    // R8
    way_really_hits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hit_any |-> hit_vec[hit_way]);
endmodule

// File: rtl/xlate_buf.sv
module xlate_buf
    import xbuf_pkg::*;
#(
    parameter int WAYS = 2,
    parameter int SETS = 128
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [1:0]        reg_sel,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              busy,
    output logic              cmd_done,
    output logic              utlb_inv,
    input  logic [19:0]       lk_vpn,
    input  logic [7:0]        lk_asid,
    output logic              lk_hit,
    output logic              lk_dup,
    output logic [31:0]       lk_data
);
    localparam int WAY_W   = $clog2(WAYS);
    localparam int SET_W   = $clog2(SETS);
    localparam int ENTRIES = WAYS * SETS;
    localparam int IDX_W   = $clog2(ENTRIES);

    typedef struct packed {
        logic [WORD_W-1:0]             tag;
        logic [WORD_W-1:0]             data;
        logic [WORD_W-1:0]             idx;
        logic                          busy;
        logic [2:0]                    op;
        logic                          done;
        logic                          inv;
        logic [SETS-1:0][WAY_W-1:0]    rr;
    } st_t;

    st_t st_d, st_q;

    logic                         mem_we;
    logic [SET_W-1:0]             p_set;
    logic [WAYS-1:0][WORD_W-1:0]  p_tags;
    logic [WAYS-1:0][WORD_W-1:0]  l_tags;
    logic [WAYS-1:0][WORD_W-1:0]  l_datas;
    logic [WORD_W-1:0]            r_tag, r_data;
    logic                         p_hit, p_dup, l_hit, l_dup;
    logic [WAY_W-1:0]             p_way, l_way;
    logic                         free_any;
    logic [WAY_W-1:0]             free_way;

    assign p_set = st_q.tag[VPN_LSB +: SET_W];

    xb_store #(.WAYS(WAYS), .SETS(SETS)) u_store (
        .clk    (clk),
        .rst_n  (rst_n),
        .we     (mem_we),
        .waddr  (st_q.idx[IDX_W-1:0]),
        .wtag   (st_q.tag),
        .wdata  (st_q.data),
        .set_a  (p_set),
        .a_tag  (p_tags),
        .set_b  (lk_vpn[SET_W-1:0]),
        .b_tag  (l_tags),
        .b_data (l_datas),
        .raddr  (st_q.idx[IDX_W-1:0]),
        .r_tag  (r_tag),
        .r_data (r_data)
    );

    xb_way_match #(.WAYS(WAYS)) u_probe_match (
        .clk      (clk),
        .rst_n    (rst_n),
        .tags     (p_tags),
        .key_vpn  (st_q.tag[WORD_W-1:VPN_LSB]),
        .key_asid (st_q.tag[ASID_W-1:0]),
        .hit_any  (p_hit),
        .hit_dup  (p_dup),
        .hit_way  (p_way)
    );

    xb_way_match #(.WAYS(WAYS)) u_look_match (
        .clk      (clk),
        .rst_n    (rst_n),
        .tags     (l_tags),
        .key_vpn  (lk_vpn),
        .key_asid (lk_asid),
        .hit_any  (l_hit),
        .hit_dup  (l_dup),
        .hit_way  (l_way)
    );

    // lowest way of the probed set whose valid bit is clear
    always_comb begin
        free_any = 1'b0;
        free_way = '0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (!p_tags[w][VALID_BIT]) begin
                free_any = 1'b1;
                free_way = WAY_W'(w);
            end
        end
    end

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        st_d.inv  = 1'b0;
        mem_we    = 1'b0;
        if (st_q.busy) begin
            st_d.busy = 1'b0;
            st_d.done = 1'b1;
            case (op_e'(st_q.op))
                OP_PROBE: begin
                    st_d.idx = '0;
                    if (!p_hit) begin
                        st_d.idx[ERR_BIT] = 1'b1;
                    end else if (p_dup) begin
                        st_d.idx[ERR_BIT] = 1'b1;
                        st_d.idx[DUP_BIT] = 1'b1;
                    end else begin
                        st_d.idx[IDX_W-1:0] = {p_set, p_way};
                    end
                end
                OP_PICK: begin
                    st_d.idx = '0;
                    st_d.idx[IDX_W-1:0] = {p_set, free_any ? free_way : st_q.rr[p_set]};
                    st_d.rr[p_set] = st_q.rr[p_set] + 1'b1;
                end
                OP_STORE: begin
                    mem_we   = 1'b1;
                    st_d.inv = 1'b1;
                end
                OP_STORE_Q: mem_we = 1'b1;
                OP_LOAD: begin
                    st_d.tag  = r_tag;
                    st_d.data = r_data;
                end
                OP_UINV: st_d.inv = 1'b1;
                default: ;
            endcase
        end else if (reg_we) begin
            case (reg_sel)
                SEL_TAG:  st_d.tag  = reg_wdata;
                SEL_DATA: st_d.data = reg_wdata;
                SEL_IDX:  st_d.idx  = reg_wdata;
                default: begin
                    st_d.busy = 1'b1;
                    st_d.op   = reg_wdata[2:0];
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        case (reg_sel)
            SEL_TAG:  reg_rdata = st_q.tag;
            SEL_DATA: reg_rdata = st_q.data;
            SEL_IDX:  reg_rdata = st_q.idx;
            default:  reg_rdata = {31'b0, st_q.busy};
        endcase
    end

    assign busy     = st_q.busy;
    assign cmd_done = st_q.done;
    assign utlb_inv = st_q.inv;
    assign lk_hit   = l_hit;
    assign lk_dup   = l_dup;
    assign lk_data  = l_hit ? l_datas[l_way] : '0;

    // R3
    one_cycle_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> !busy);
    // R3
    done_after_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_done |-> $past(busy));
    // R4
    inv_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        utlb_inv |-> cmd_done);
    // R9
    dup_code_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.idx[DUP_BIT] && cmd_done |-> st_q.idx[ERR_BIT]);
endmodule

// File: tb/sim_xlate_buf.sv
module sim_xlate_buf;
    localparam int WAYS = 2;
    localparam int SETS = 128;
    localparam int ENT  = WAYS * SETS;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [1:0]  reg_sel = 2'd0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        busy, cmd_done, utlb_inv;
    logic [19:0] lk_vpn = '0;
    logic [7:0]  lk_asid = '0;
    logic        lk_hit, lk_dup;
    logic [31:0] lk_data;

    always #5 clk = ~clk;

    xlate_buf #(.WAYS(WAYS), .SETS(SETS)) u0 (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .busy(busy),
        .cmd_done(cmd_done), .utlb_inv(utlb_inv), .lk_vpn(lk_vpn),
        .lk_asid(lk_asid), .lk_hit(lk_hit), .lk_dup(lk_dup), .lk_data(lk_data)
    );

    // behavioural reference model
    logic [31:0] m_tag, m_data, m_idx;
    bit          m_busy, m_done, m_inv;
    int          m_op;
    logic [31:0] mt [ENT];
    logic [31:0] md [ENT];
    int          mrr [SETS];

    function automatic bit m_match(logic [31:0] e, logic [19:0] vpn, logic [7:0] asid);
        return e[9] && (e[31:12] == vpn) && (e[8] || e[7:0] == asid);
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_tag = 0; m_data = 0; m_idx = 0; m_busy = 0; m_done = 0; m_inv = 0; m_op = 0;
            for (int i = 0; i < ENT; i++) begin mt[i] = 0; md[i] = 0; end
            for (int s = 0; s < SETS; s++) mrr[s] = 0;
        end else begin
            m_done = 0; m_inv = 0;
            if (m_busy) begin
                int s, cnt, first, fr;
                m_busy = 0; m_done = 1;
                s = int'(m_tag[31:12]) % SETS;
                case (m_op)
                    1: begin
                        cnt = 0; first = 0;
                        for (int w = 0; w < WAYS; w++)
                            if (m_match(mt[s*WAYS+w], m_tag[31:12], m_tag[7:0])) begin
                                if (cnt == 0) first = w;
                                cnt++;
                            end
                        if (cnt == 0)      m_idx = 32'h8000_0000;
                        else if (cnt > 1)  m_idx = 32'hC000_0000;
                        else               m_idx = s*WAYS + first;
                    end
                    2: begin
                        fr = -1;
                        for (int w = WAYS - 1; w >= 0; w--) if (!mt[s*WAYS+w][9]) fr = w;
                        m_idx = (fr >= 0) ? s*WAYS + fr : s*WAYS + mrr[s];
                        mrr[s] = (mrr[s] + 1) % WAYS;
                    end
                    3, 4: begin
                        mt[m_idx % ENT] = m_tag; md[m_idx % ENT] = m_data;
                        if (m_op == 3) m_inv = 1;
                    end
                    5: begin m_tag = mt[m_idx % ENT]; m_data = md[m_idx % ENT]; end
                    6: m_inv = 1;
                    default: ;
                endcase
            end else if (reg_we) begin
                case (reg_sel)
                    0: m_tag = reg_wdata;
                    1: m_data = reg_wdata;
                    2: m_idx = reg_wdata;
                    default: begin m_busy = 1; m_op = int'(reg_wdata[2:0]); end
                endcase
            end
        end
    end

    int    checks = 0;
    int    errors = 0;
    string cur_req = "R1";

    task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic compare_all();
        logic [31:0] rexp;
        logic [31:0] dexp;
        bit h, d;
        int s, n;
        case (reg_sel)
            2'd0: rexp = m_tag;
            2'd1: rexp = m_data;
            2'd2: rexp = m_idx;
            default: rexp = {31'b0, m_busy};
        endcase
        s = int'(lk_vpn) % SETS; n = 0; dexp = 0;
        for (int w = 0; w < WAYS; w++)
            if (m_match(mt[s*WAYS+w], lk_vpn, lk_asid)) begin
                if (n == 0) dexp = md[s*WAYS+w];
                n++;
            end
        h = (n > 0); d = (n > 1);
        chk(cur_req, "reg_rdata", reg_rdata, rexp);
        chk(cur_req, "busy", {31'b0, busy}, {31'b0, m_busy});
        chk(cur_req, "cmd_done", {31'b0, cmd_done}, {31'b0, m_done});
        chk(cur_req, "utlb_inv", {31'b0, utlb_inv}, {31'b0, m_inv});
        chk(cur_req, "lk_hit", {31'b0, lk_hit}, {31'b0, h});
        chk(cur_req, "lk_dup", {31'b0, lk_dup}, {31'b0, d});
        chk(cur_req, "lk_data", lk_data, dexp);
    endtask

    task automatic tick();
        @(negedge clk);
        if (rst_n) compare_all();
    endtask

    task automatic wreg(logic [1:0] sel, logic [31:0] d);
        reg_we = 1'b1; reg_sel = sel; reg_wdata = d;
        tick();
        reg_we = 1'b0;
    endtask

    task automatic run_op(int code, output bit inv_seen);
        wreg(2'd3, code);
        chk("R3", "busy after command", {31'b0, busy}, 32'd1);
        tick();
        chk("R3", "done strobe", {31'b0, cmd_done}, 32'd1);
        inv_seen = utlb_inv;
        tick();
    endtask

    task automatic rd(logic [1:0] sel, string req, logic [31:0] exp);
        reg_sel = sel;
        tick();
        chk(req, "register readback", reg_rdata, exp);
    endtask

    task automatic look(logic [19:0] v, logic [7:0] a);
        lk_vpn = v; lk_asid = a;
        tick();
    endtask

    function automatic logic [31:0] mk(logic [19:0] vpn, logic [7:0] asid, bit g);
        return {vpn, 2'b00, 1'b1, g, asid};
    endfunction

    bit wd_expired = 0;
    bit iv;

    initial begin
        #2000000;
        wd_expired = 1;
        errors++; checks++;
        $display("FAIL watchdog: actual=expired expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        cur_req = "R1";
        rd(2'd0, "R1", 32'h0);
        rd(2'd1, "R1", 32'h0);
        rd(2'd2, "R1", 32'h0);
        look(20'h5, 8'h3);
        chk("R1", "lk_hit after reset", {31'b0, lk_hit}, 32'd0);
        chk("R1", "done after reset", {31'b0, cmd_done}, 32'd0);

        // R2 register access
        cur_req = "R2";
        wreg(2'd0, 32'h1234_5678); wreg(2'd1, 32'h9ABC_DEF0); wreg(2'd2, 32'h5);
        rd(2'd0, "R2", 32'h1234_5678);
        rd(2'd1, "R2", 32'h9ABC_DEF0);
        rd(2'd2, "R2", 32'h5);
        rd(2'd3, "R2", 32'h0);

        // R4 store with invalidate
        cur_req = "R4";
        wreg(2'd0, mk(20'h5, 8'h3, 0)); wreg(2'd1, 32'hABCD_E03F); wreg(2'd2, 32'd10);
        run_op(3, iv);
        chk("R4", "inv on store", {31'b0, iv}, 32'd1);

        // R5 quiet store
        cur_req = "R5";
        wreg(2'd0, mk(20'h85, 8'h3, 0)); wreg(2'd1, 32'h1234_5007); wreg(2'd2, 32'd11);
        run_op(4, iv);
        chk("R5", "no inv on quiet store", {31'b0, iv}, 32'd0);

        // R11 lookup
        cur_req = "R11";
        look(20'h5, 8'h3);
        chk("R11", "lk_data private hit", lk_data, 32'hABCD_E03F);
        look(20'h5, 8'h4);
        chk("R11", "wrong asid misses", {31'b0, lk_hit}, 32'd0);
        wreg(2'd0, mk(20'h7, 8'h0, 1)); wreg(2'd1, 32'h7777_7001); wreg(2'd2, 32'd14);
        run_op(3, iv);
        look(20'h7, 8'h9A);
        chk("R11", "global hit any asid", lk_data, 32'h7777_7001);

        // R8 probe hit
        cur_req = "R8";
        wreg(2'd0, mk(20'h85, 8'h3, 0));
        run_op(1, iv);
        rd(2'd2, "R8", 32'd11);
        wreg(2'd0, mk(20'h7, 8'h55, 0));
        run_op(1, iv);
        rd(2'd2, "R8", 32'd14);

        // R9 miss and duplicate
        cur_req = "R9";
        wreg(2'd0, mk(20'h5, 8'h4, 0));
        run_op(1, iv);
        rd(2'd2, "R9", 32'h8000_0000);
        wreg(2'd0, mk(20'h105, 8'h3, 0));
        run_op(1, iv);
        rd(2'd2, "R9", 32'h8000_0000);
        wreg(2'd0, mk(20'h25, 8'h1, 0)); wreg(2'd1, 32'h2500_0003);
        wreg(2'd2, 32'h4A); run_op(3, iv);
        wreg(2'd2, 32'h4B); run_op(4, iv);
        run_op(1, iv);
        rd(2'd2, "R9", 32'hC000_0000);
        look(20'h25, 8'h1);
        chk("R11", "lk_dup on duplicate", {31'b0, lk_dup}, 32'd1);

        // R7 load
        cur_req = "R7";
        wreg(2'd2, 32'd10);
        run_op(5, iv);
        rd(2'd0, "R7", mk(20'h5, 8'h3, 0));
        rd(2'd1, "R7", 32'hABCD_E03F);

        // R6 invalidate only
        cur_req = "R6";
        run_op(6, iv);
        chk("R6", "inv on invalidate command", {31'b0, iv}, 32'd1);
        look(20'h5, 8'h3);
        chk("R6", "entry kept after invalidate", lk_data, 32'hABCD_E03F);

        // R10 pick slot
        cur_req = "R10";
        wreg(2'd0, mk(20'h30, 8'h2, 0));
        run_op(2, iv);
        rd(2'd2, "R10", 32'h60);
        run_op(3, iv);
        run_op(2, iv);
        rd(2'd2, "R10", 32'h61);
        run_op(3, iv);
        run_op(2, iv);
        rd(2'd2, "R10", 32'h60);
        run_op(2, iv);
        rd(2'd2, "R10", 32'h61);

        // R3 writes while busy are ignored
        cur_req = "R3";
        wreg(2'd0, 32'h0000_1111);
        wreg(2'd3, 32'd6);
        wreg(2'd0, 32'hDEAD_0000);
        tick();
        rd(2'd0, "R3", 32'h0000_1111);

        // mixed pseudo-random traffic in a few sets
        cur_req = "R8";
        for (int k = 0; k < 600; k++) begin
            int pick;
            pick = int'($urandom_range(0, 9));
            lk_vpn  = {16'h0, 4'($urandom_range(0, 3)), 4'h0} | 20'($urandom_range(0, 1));
            lk_asid = 8'($urandom_range(0, 2));
            if (pick < 3)
                wreg(2'd0, {12'h0, 4'($urandom_range(0, 3)), 3'h0, 1'($urandom_range(0, 1)),
                            2'b00, 1'($urandom_range(0, 3) != 0), 1'($urandom_range(0, 1)),
                            8'($urandom_range(0, 2))});
            else if (pick == 3) wreg(2'd1, $urandom);
            else if (pick == 4) wreg(2'd2, 32'($urandom_range(0, ENT - 1)));
            else begin
                reg_sel = 2'($urandom_range(0, 3));
                wreg(2'd3, 32'($urandom_range(0, 7)));
                reg_sel = 2'($urandom_range(0, 3));
                tick();
            end
        end

        if (!wd_expired) begin
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule